// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes a parallel pair of 24-bit two's-complement samples, one for the left channel and one for the right, and shifts them out one bit at a time on a single serial data line. A frame lasts 64 serial clock periods and is marked by a word-select clock. The first half of the frame carries the left sample and the second half carries the right sample. Both clocks reach the block as inputs and may come from a local divider or from another device. The block samples them with its own system clock, so every serial edge must last several system clocks.

Two framings are supported. In left-justified framing the word select is high for the left channel, and the MSB leaves on the first serial clock fall after a word-select edge. In I2S framing the word select is low for the left channel, and the MSB leaves one serial clock later. The framing is not set by software. While reset is low the data driver is released, so the level that a board resistor places on the data pin can be read. On the first system clock after reset is released, that level is captured: high selects I2S and low selects left-justified. A new sample pair is taken at the start of every frame. If no valid pair is offered at that moment, the last pair is sent again.

Top module: `stereo_serial_tx`

## Requirements
- R1: Each channel word is 24 bits, two's complement, sent MSB first (bit 23, then down to bit 0).
- R2: `sd_out` changes only in the system clock that follows a detected falling edge of `sclk`, and it holds its value through the whole high phase of `sclk` that follows.
- R3: `sd_oe` is 0 while `rst_n` is low and stays 0 during the first system clock after release. On that clock `strap_in` is captured (1 selects I2S, 0 selects left-justified), and `sd_oe` is 1 from then on. Later changes of `strap_in` have no effect on the framing.
- R4: In left-justified framing, `lrck`=1 marks the left half. Bit 23 is sent in slot 0 (the first `sclk` fall after the `lrck` edge) and bit 0 in slot 23.
- R5: In I2S framing, `lrck`=0 marks the left half. Slot 0 carries 0, bit 23 is sent in slot 1 and bit 0 in slot 24.
- R6: A frame is 64 `sclk` periods, 32 slots for each half, left half first. The slots after the LSB carry 0: 8 slots in left-justified framing and 7 slots in I2S framing.
- R7: At the `sclk` fall that opens a left half, the pair on `left_in`/`right_in` is taken if `pair_valid` is 1. `pair_req` pulses high for exactly one system clock right after each such frame start.
- R8: If `pair_valid` is 0 at a frame start, the previously taken pair is sent again unchanged.
- R9: After reset, and until the first `lrck` edge has been seen at an `sclk` fall, `sd_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Word-select (channel) clock |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| pair_valid | input | 1 | The sample pair on the inputs is valid |
| strap_in | input | 1 | Level sensed on the data pin, read once after reset |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for the data pin driver |
| pair_req | output | 1 | One-clock pulse after each frame start |

## Verification
The checks assume that `sclk` and `lrck` are synchronous to `clk` and change away from its rising edge. They also assume that each `sclk` phase lasts at least two system clocks, so that every fall is seen exactly once, and that `lrck` changes only together with an `sclk` fall. The stimulus drives both clocks on the falling edge of `clk` and holds each `sclk` phase for four system clocks. It moves `lrck` only in the same step that lowers `sclk`, and it keeps exactly 64 serial periods in each frame, after a short lead-in with `lrck` parked at the right-channel level.

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int WIDTH = 24,
  parameter int SLOTS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             lrck,
  input  logic [WIDTH-1:0] left_in,
  input  logic [WIDTH-1:0] right_in,
  input  logic             pair_valid,
  input  logic             strap_in,
  output logic             sd_out,
  output logic             sd_oe,
  output logic             pair_req
);
  localparam int SW = $clog2(SLOTS);

  logic             locked, fmt_i2s, sclk_q, lrck_q, seen, synced;
  logic [SW-1:0]    slot;
  logic [WIDTH-1:0] hold_l, hold_r;

  wire sclk_fall   = locked & sclk_q & ~sclk;
  wire lr_edge     = seen & (lrck != lrck_q);
  wire is_left     = fmt_i2s ? ~lrck : lrck;
  wire frame_start = sclk_fall & lr_edge & is_left;
  wire take_pair   = frame_start & pair_valid;

  wire [SW-1:0] slot_n = lr_edge ? '0 :
                         (slot == SW'(SLOTS-1)) ? slot : slot + 1'b1;

  wire [WIDTH-1:0] word = is_left ? (take_pair ? left_in : hold_l)
                                  : hold_r;

  wire [SW-1:0]    rel    = slot_n - SW'(fmt_i2s);
  wire             in_rng = (slot_n >= SW'(fmt_i2s)) &&
                            ({1'b0, rel} < (SW+1)'(WIDTH));
  wire [WIDTH-1:0] sh     = word << rel;
  wire             bit_n  = (lr_edge | synced) & in_rng & sh[WIDTH-1];

  assign sd_oe = locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      fmt_i2s  <= 1'b0;
      sclk_q   <= 1'b0;
      lrck_q   <= 1'b0;
      seen     <= 1'b0;
      synced   <= 1'b0;
      slot     <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      sd_out   <= 1'b0;
      pair_req <= 1'b0;
    end else begin
      sclk_q   <= sclk;
      pair_req <= frame_start;
      if (!locked) begin
        locked  <= 1'b1;
        fmt_i2s <= strap_in;
      end
      if (sclk_fall) begin
        lrck_q <= lrck;
        seen   <= 1'b1;
        slot   <= slot_n;
        sd_out <= bit_n;
        if (lr_edge) synced <= 1'b1;
        if (take_pair) begin
          hold_l <= left_in;
          hold_r <= right_in;
        end
      end
    end
  end
endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk_fall,
  input logic fmt_i2s,
  input logic sd_out,
  input logic sd_oe,
  input logic pair_req
);
  AST_OE_LOW_IN_RESET: assert property (@(posedge clk) !rst_n |-> !sd_oe); // R3
  AST_OE_HELD_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !sd_oe); // R3
  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) sd_oe |=> $stable(fmt_i2s)); // R3
  AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sd_out) |-> $past(sclk_fall)); // R2
  AST_REQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) pair_req |-> $past(sclk_fall)); // R7
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pair_req |=> !pair_req); // R7
endmodule

bind stereo_serial_tx stereo_serial_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_fall(sclk_fall), .fmt_i2s(fmt_i2s),
  .sd_out(sd_out), .sd_oe(sd_oe), .pair_req(pair_req)
);

// File: tb/sim_stereo_serial_tx.sv
`timescale 1ns/1ps
module sim_stereo_serial_tx;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, lrck = 1'b0;
  logic [23:0] left_in = '0, right_in = '0;
  logic pair_valid = 1'b0, strap_in = 1'b0;
  logic sd_out, sd_oe, pair_req;

  int tests = 0, fails = 0, req_cnt = 0, cycles = 0;
  bit bfmt = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  stereo_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .lrck(lrck),
    .left_in(left_in), .right_in(right_in), .pair_valid(pair_valid),
    .strap_in(strap_in), .sd_out(sd_out), .sd_oe(sd_oe), .pair_req(pair_req)
  );

  always @(posedge clk) if (rst_n && pair_req) req_cnt++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_half(input logic [23:0] w, input bit i2s);
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) begin
      int p = k - int'(i2s);
      if (p >= 0 && p < 24) v[31-k] = w[23-p];
    end
    return v;
  endfunction

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_in = strap; sclk = 1'b1; lrck = strap;
    repeat (3) @(negedge clk);
    chk(sd_oe === 1'b0, "R3", "sd_oe during reset", 64'(sd_oe), 0);
    rst_n = 1'b1;
    bfmt = strap;
    repeat (3) @(negedge clk);
    chk(sd_oe === 1'b1, "R3", "sd_oe after release", 64'(sd_oe), 1);
  endtask

  task automatic warmup(input int n);
    bit bad = 1'b0;
    for (int s = 0; s < n; s++) begin
      sclk = 1'b0; lrck = bfmt;
      repeat (4) @(negedge clk);
      if (sd_out !== 1'b0) bad = 1'b1;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    chk(!bad, "R9", "zero before first lrck edge", 64'(bad), 0);
  endtask

  task automatic run_frame(input logic [23:0] l, input logic [23:0] r, input logic v,
                           input logic [23:0] el, input logic [23:0] er, input string what);
    logic [63:0] bits = '0;
    bit unstable = 1'b0;
    int req0 = req_cnt;
    left_in = l; right_in = r; pair_valid = v;
    for (int s = 0; s < 64; s++) begin
      sclk = 1'b0;
      lrck = bfmt ? (s >= 32) : (s < 32);
      repeat (4) @(negedge clk);
      bits[63-s] = sd_out;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      if (sd_out !== bits[63-s]) unstable = 1'b1;
    end
    chk(!unstable, "R2", {what, " data held while sclk high"}, 64'(unstable), 0);
    chk(bits[63:32] === exp_half(el, bfmt), bfmt ? "R5" : "R4",
        {what, " left half (R1/R6)"}, 64'(bits[63:32]), 64'(exp_half(el, bfmt)));
    chk(bits[31:0] === exp_half(er, bfmt), bfmt ? "R5" : "R4",
        {what, " right half (R1/R6)"}, 64'(bits[31:0]), 64'(exp_half(er, bfmt)));
    chk(req_cnt - req0 == 1, "R7", {what, " pair_req pulses"}, 64'(req_cnt - req0), 1);
  endtask

  task automatic test_left_justified;
    do_reset(1'b0);
    warmup(4);
    run_frame(24'hA5C3F1, 24'h123456, 1'b1, 24'hA5C3F1, 24'h123456, "lj frame a");
    run_frame(24'h800001, 24'h7FFFFE, 1'b1, 24'h800001, 24'h7FFFFE, "lj frame b");
  endtask

  task automatic test_repeat_lj;
    // R8: no valid pair, previous pair repeats
    run_frame(24'h0F0F0F, 24'hF0F0F0, 1'b0, 24'h800001, 24'h7FFFFE, "lj repeat R8");
  endtask

  task automatic test_strap_ignored;
    // R3: strap change after lock has no effect on framing
    strap_in = 1'b1;
    run_frame(24'hFFFFFF, 24'h000001, 1'b1, 24'hFFFFFF, 24'h000001, "lj strap change R3");
  endtask

  task automatic test_i2s;
    do_reset(1'b1);
    warmup(3);
    run_frame(24'hC00003, 24'h5AA5A5, 1'b1, 24'hC00003, 24'h5AA5A5, "i2s frame c");
    run_frame(24'h000001, 24'h800000, 1'b1, 24'h000001, 24'h800000, "i2s frame d");
    run_frame(24'h333333, 24'h444444, 1'b0, 24'h000001, 24'h800000, "i2s repeat R8");
  endtask

  initial begin
    test_left_justified();
    test_repeat_lj();
    test_strap_ignored();
    test_i2s();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule